// File: doc/BRIEF.md
# Card Power-Down Sequencer

This block takes a smart card interface down in a fixed, timed order whenever a fault, a removal or a power-off request appears. It watches a set of trigger events. They are a hardware overcurrent fault, a supply-voltage fault raised by hardware or by software, and card removal while presence detection is enabled. They also include a software power-off request, a rising edge on the asynchronous host supply-command input, a supply failure while supply monitoring is enabled, and the chip reset line falling. Any one of these starts a sequence. Once started, the sequence cannot be stopped or restarted by any input until it completes.

The block runs on the DC/DC converter clock. A free-running prescaler divides it into a step unit Td of `TD_CYCLES` clocks (8 by default), and its half-Td boundaries form the grid on which the sequence starts. The sequence emits one-cycle strobes, and the surrounding register logic applies them to the card controls. At T0 the reset strobe asks for card reset low and for the shutdown flag to be set. At T0+5·Td the clock-stop strobe asks for the clock to be stopped and the I/O to be isolated. At T0+6·Td the I/O-release strobe asks for the I/O drive to be dropped. At T0+7·Td the supply-off strobe asks for the voltage selection to be forced to 00, and a done pulse accompanies it. Because T0 snaps to a half-Td boundary, the interval from trigger to T0 lies between one clock and half a Td.

Top module: `card_deact_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, busy_o and all strobes (rst_low_o, clk_stop_o, io_off_o, vsel_zero_o, done_o) are 0.
- R2: With a free-running phase counter that is 0 in the first cycle after reset and counts modulo TD_CYCLES, a trigger sampled in cycle n puts T0 in the first cycle j > n whose phase is a multiple of TD_CYCLES/2. rst_low_o is high in cycle j only.
- R3: clk_stop_o is high only in cycle j+5·TD_CYCLES, io_off_o only in j+6·TD_CYCLES, and vsel_zero_o and done_o only in j+7·TD_CYCLES. Each is a one-cycle strobe.
- R4: busy_o is high from cycle n+1 through cycle j+7·TD_CYCLES inclusive, and is low in the cycle after done_o.
- R5: Any trigger arriving while busy_o is high, including in the done cycle, has no effect on the strobe timing or on busy_o.
- R6: A one-cycle pulse on ocp_hw_i, vf_hw_i, vf_sw_i or sw_off_i is a trigger. A pulse on ocp_sw_i (the software-written overcurrent flag) is not.
- R7: A transition of card_present_i from 1 to 0 triggers only while detect_en_i is 1. A rise of supply_fail_i triggers only while supply_mon_en_i is 1.
- R8: host_cmd_i passes through a 2-stage synchroniser. Its rising edge in cycle n acts as a trigger sampled in cycle n+2, and its falling edge never triggers.
- R9: chip_rstn_i going from 1 to 0 is a trigger, and its return to 1 is not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DC/DC converter clock |
| rst | input | 1 | Synchronous active-high reset |
| ocp_hw_i | input | 1 | Overcurrent fault set by hardware (pulse) |
| ocp_sw_i | input | 1 | Overcurrent flag written by software (pulse, no effect) |
| vf_hw_i | input | 1 | Supply-voltage fault set by hardware (pulse) |
| vf_sw_i | input | 1 | Supply-voltage fault written by software (pulse) |
| detect_en_i | input | 1 | Presence detection enable |
| card_present_i | input | 1 | Card presence level |
| sw_off_i | input | 1 | Software power-off request (pulse) |
| host_cmd_i | input | 1 | Asynchronous host supply-command input |
| supply_fail_i | input | 1 | Host supply failure level |
| supply_mon_en_i | input | 1 | Supply monitoring enable |
| chip_rstn_i | input | 1 | Chip reset line, active low |
| busy_o | output | 1 | Sequence in progress |
| rst_low_o | output | 1 | T0 strobe: card reset low, shutdown flag set |
| clk_stop_o | output | 1 | Strobe: stop card clock, isolate I/O |
| io_off_o | output | 1 | Strobe: drop card I/O drive |
| vsel_zero_o | output | 1 | Strobe: force voltage selection to 00 |
| done_o | output | 1 | Sequence complete pulse |

## Verification
A prescaler phase that drifts or resets wrongly shifts T0 away from the half-Td grid. For trigger phases that sit right before a boundary, this becomes visible at rst_low_o within one half-Td. A step counter that restarts or skips moves the later strobes by whole cycles, which appears at clk_stop_o 5·Td after T0. An FSM that can be re-entered or left early shows busy_o staying high past done_o, or a second rst_low_o strobe, within the same sequence window. A broken trigger qualifier or edge detector shows up as busy_o rising one cycle after a stimulus that must be ignored, or staying low after one that must not.

// File: rtl/cdseq_pkg.sv
package cdseq_pkg;

    localparam int TD_DEFAULT = 8;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ALIGN = 2'd1,
        ST_RUN   = 2'd2
    } seq_state_t;

    // One bit per trigger candidate; ocp_sw sits in the LSB and is masked off.
    typedef struct packed {
        logic ocp_hw;
        logic vf_hw;
        logic vf_sw;
        logic extract;
        logic sw_off;
        logic host_cmd;
        logic supply;
        logic chip_rst;
        logic ocp_sw;
    } trig_vec_t;

    localparam logic [8:0] TRIG_ENABLE = 9'h1FE;

    typedef struct packed {
        logic rst_low;
        logic clk_stop;
        logic io_off;
        logic vsel_zero;
    } step_vec_t;

    function automatic int unsigned step_cycle(input int unsigned td,
                                               input int unsigned units);
        return td * units;
    endfunction

    function automatic logic trig_any(input trig_vec_t v);
        return |(v & TRIG_ENABLE);
    endfunction

endpackage

// File: rtl/cdseq_trigger.sv
module cdseq_trigger
    import cdseq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      ocp_hw_i,
    input  logic      ocp_sw_i,
    input  logic      vf_hw_i,
    input  logic      vf_sw_i,
    input  logic      detect_en_i,
    input  logic      card_present_i,
    input  logic      sw_off_i,
    input  logic      host_cmd_i,
    input  logic      supply_fail_i,
    input  logic      supply_mon_en_i,
    input  logic      chip_rstn_i,
    output trig_vec_t src_o,
    output logic      any_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   host_prev_q;
    logic                   host_sync;
    logic                   extract_lvl;
    logic                   extract_prev_q;
    logic                   supply_lvl;
    logic                   supply_prev_q;
    logic                   chip_prev_q;

    generate
        if (SYNC_STAGES == 1) begin : g_sync_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= host_cmd_i;
            end
        end else begin : g_sync_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], host_cmd_i};
            end
        end
    endgenerate

    assign host_sync   = sync_q[SYNC_STAGES-1];
    assign extract_lvl = detect_en_i & ~card_present_i;
    assign supply_lvl  = supply_mon_en_i & supply_fail_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            host_prev_q    <= 1'b0;
            extract_prev_q <= 1'b0;
            supply_prev_q  <= 1'b0;
            chip_prev_q    <= 1'b1;
        end else begin
            host_prev_q    <= host_sync;
            extract_prev_q <= extract_lvl;
            supply_prev_q  <= supply_lvl;
            chip_prev_q    <= chip_rstn_i;
        end
    end

    always_comb begin
        src_o          = '0;
        src_o.ocp_hw   = ocp_hw_i;
        src_o.vf_hw    = vf_hw_i;
        src_o.vf_sw    = vf_sw_i;
        src_o.extract  = extract_lvl & ~extract_prev_q;
        src_o.sw_off   = sw_off_i;
        src_o.host_cmd = host_sync & ~host_prev_q;
        src_o.supply   = supply_lvl & ~supply_prev_q;
        src_o.chip_rst = chip_prev_q & ~chip_rstn_i;
        src_o.ocp_sw   = ocp_sw_i;
    end

    assign any_o = trig_any(src_o);

    // R8
    host_edge_chk: assert property (@(posedge clk) disable iff (rst)
        src_o.host_cmd |=> !src_o.host_cmd);

    // R6
    ocp_sw_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (src_o == trig_vec_t'(9'h001)) |-> !any_o);

endmodule

// File: rtl/cdseq_timebase.sv
module cdseq_timebase #(
    parameter int TD_CYCLES = 8
) (
    input  logic clk,
    input  logic rst,
    output logic half_tick_o
);

    localparam int PSW  = (TD_CYCLES > 2) ? $clog2(TD_CYCLES) : 1;
    localparam int HALF = TD_CYCLES / 2;

    logic [PSW-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (rst)                                 phase_q <= '0;
        else if (phase_q == PSW'(TD_CYCLES - 1)) phase_q <= '0;
        else                                     phase_q <= phase_q + 1'b1;
    end

    assign half_tick_o = (phase_q == '0) || (phase_q == PSW'(HALF));

    // R2
    half_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        half_tick_o |=> !half_tick_o);

endmodule

// File: rtl/cdseq_fsm.sv
module cdseq_fsm
    import cdseq_pkg::*;
#(
    parameter int TD_CYCLES = 8,
    parameter int CLK_UNITS = 5,
    parameter int IO_UNITS  = 6,
    parameter int OFF_UNITS = 7
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      trig_i,
    input  logic      half_tick_i,
    output logic      busy_o,
    output step_vec_t step_o,
    output logic      done_o
);

    localparam int CLK_AT_I = int'(step_cycle(TD_CYCLES, CLK_UNITS));
    localparam int IO_AT_I  = int'(step_cycle(TD_CYCLES, IO_UNITS));
    localparam int OFF_AT_I = int'(step_cycle(TD_CYCLES, OFF_UNITS));
    localparam int CW       = $clog2(OFF_AT_I + 1);
    localparam logic [CW-1:0] CLK_AT = CW'(CLK_AT_I);
    localparam logic [CW-1:0] IO_AT  = CW'(IO_AT_I);
    localparam logic [CW-1:0] OFF_AT = CW'(OFF_AT_I);

    seq_state_t    state_q;
    logic [CW-1:0] cnt_q;
    logic          at_off;

    assign at_off = (state_q == ST_RUN) && (cnt_q == OFF_AT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (trig_i) state_q <= ST_ALIGN;
                end
                ST_ALIGN: begin
                    if (half_tick_i) begin
                        state_q <= ST_RUN;
                        cnt_q   <= CW'(1);
                    end
                end
                ST_RUN: begin
                    if (at_off) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    always_comb begin
        step_o           = '0;
        step_o.rst_low   = (state_q == ST_ALIGN) && half_tick_i;
        step_o.clk_stop  = (state_q == ST_RUN) && (cnt_q == CLK_AT);
        step_o.io_off    = (state_q == ST_RUN) && (cnt_q == IO_AT);
        step_o.vsel_zero = at_off;
    end

    assign busy_o = (state_q != ST_IDLE);
    assign done_o = at_off;

    // R5
    no_abort_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o) |=> busy_o);

    // R3
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(step_o));

endmodule

// File: rtl/card_deact_seq.sv
module card_deact_seq
    import cdseq_pkg::*;
#(
    parameter int TD_CYCLES   = TD_DEFAULT,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ocp_hw_i,
    input  logic ocp_sw_i,
    input  logic vf_hw_i,
    input  logic vf_sw_i,
    input  logic detect_en_i,
    input  logic card_present_i,
    input  logic sw_off_i,
    input  logic host_cmd_i,
    input  logic supply_fail_i,
    input  logic supply_mon_en_i,
    input  logic chip_rstn_i,
    output logic busy_o,
    output logic rst_low_o,
    output logic clk_stop_o,
    output logic io_off_o,
    output logic vsel_zero_o,
    output logic done_o
);

    trig_vec_t src;
    logic      trig_any_w;
    logic      half_tick;
    step_vec_t step;

    cdseq_trigger #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk             (clk),
        .rst             (rst),
        .ocp_hw_i        (ocp_hw_i),
        .ocp_sw_i        (ocp_sw_i),
        .vf_hw_i         (vf_hw_i),
        .vf_sw_i         (vf_sw_i),
        .detect_en_i     (detect_en_i),
        .card_present_i  (card_present_i),
        .sw_off_i        (sw_off_i),
        .host_cmd_i      (host_cmd_i),
        .supply_fail_i   (supply_fail_i),
        .supply_mon_en_i (supply_mon_en_i),
        .chip_rstn_i     (chip_rstn_i),
        .src_o           (src),
        .any_o           (trig_any_w)
    );

    cdseq_timebase #(.TD_CYCLES(TD_CYCLES)) u_tb (
        .clk         (clk),
        .rst         (rst),
        .half_tick_o (half_tick)
    );

    cdseq_fsm #(.TD_CYCLES(TD_CYCLES)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .trig_i      (trig_any_w),
        .half_tick_i (half_tick),
        .busy_o      (busy_o),
        .step_o      (step),
        .done_o      (done_o)
    );

    assign rst_low_o   = step.rst_low;
    assign clk_stop_o  = step.clk_stop;
    assign io_off_o    = step.io_off;
    assign vsel_zero_o = step.vsel_zero;

    // R4
    start_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_o) |-> $past(trig_any_w));

    // R4
    idle_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !busy_o);

    // R2
    t0_on_grid_chk: assert property (@(posedge clk) disable iff (rst)
        rst_low_o |-> half_tick);

    // R3
    t0_single_chk: assert property (@(posedge clk) disable iff (rst)
        rst_low_o |=> (busy_o && !rst_low_o));

endmodule

// File: tb/card_deact_seq_test.sv
module card_deact_seq_test;

    localparam int CLK_PERIOD = 10;
    localparam int TD   = 8;
    localparam int HALF = TD / 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ocp_hw = 0, ocp_sw = 0, vf_hw = 0, vf_sw = 0;
    logic detect_en = 0, card_present = 1, sw_off = 0, host_cmd = 0;
    logic supply_fail = 0, supply_mon_en = 0, chip_rstn = 1;
    logic busy, rst_low, clk_stop, io_off, vsel_zero, done;

    int total = 0;
    int bad   = 0;
    int bn    = 0;
    bit finished = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) bn <= 0;
        else     bn <= bn + 1;
    end

    card_deact_seq #(.TD_CYCLES(TD)) uut (
        .clk(clk), .rst(rst),
        .ocp_hw_i(ocp_hw), .ocp_sw_i(ocp_sw), .vf_hw_i(vf_hw), .vf_sw_i(vf_sw),
        .detect_en_i(detect_en), .card_present_i(card_present), .sw_off_i(sw_off),
        .host_cmd_i(host_cmd), .supply_fail_i(supply_fail),
        .supply_mon_en_i(supply_mon_en), .chip_rstn_i(chip_rstn),
        .busy_o(busy), .rst_low_o(rst_low), .clk_stop_o(clk_stop),
        .io_off_o(io_off), .vsel_zero_o(vsel_zero), .done_o(done)
    );

    function automatic logic [5:0] outs();
        return {busy, rst_low, clk_stop, io_off, vsel_zero, done};
    endfunction

    task automatic check(input logic [5:0] act, input logic [5:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s cycle=%0d actual=%b expected=%b", req, bn, act, exp);
        end
    endtask

    task automatic check_idle(input int cycles, input string req);
        for (int i = 0; i < cycles; i++) begin
            check(outs(), 6'b0, req);
            @(negedge clk);
        end
    endtask

    // kind: 0 ocp_hw, 1 vf_hw, 2 vf_sw, 3 removal, 4 sw_off, 5 host_cmd, 6 supply, 7 chip reset
    task automatic run_seq(input int kind, input int phase);
        int n, j, c;
        logic [5:0] exp;
        string req;
        case (kind)
            3:       req = "R7";
            5:       req = "R8";
            7:       req = "R9";
            default: req = "R6";
        endcase
        if (kind == 3) detect_en = 1'b1;
        if (kind == 6) supply_mon_en = 1'b1;
        @(negedge clk);
        while ((bn % TD) != phase) @(negedge clk);
        case (kind)
            0: ocp_hw = 1'b1;
            1: vf_hw = 1'b1;
            2: vf_sw = 1'b1;
            3: card_present = 1'b0;
            4: sw_off = 1'b1;
            5: host_cmd = 1'b1;
            6: supply_fail = 1'b1;
            default: chip_rstn = 1'b0;
        endcase
        n = bn;
        if (kind == 5) n = n + 2;
        j = ((n + 1 + HALF - 1) / HALF) * HALF;
        @(negedge clk);
        ocp_hw = 0; vf_hw = 0; vf_sw = 0; sw_off = 0;
        for (int k = 0; k < 75; k++) begin
            c = bn;
            exp = '0;
            exp[5] = (c >= n + 1) && (c <= j + 7 * TD);
            exp[4] = (c == j);
            exp[3] = (c == j + 5 * TD);
            exp[2] = (c == j + 6 * TD);
            exp[1] = (c == j + 7 * TD);
            exp[0] = (c == j + 7 * TD);
            if (c == j)                check(outs(), exp, {req, " R2 T0"});
            else if (exp[3:0] != 4'b0) check(outs(), exp, {req, " R3 step"});
            else                       check(outs(), exp, {req, " R4 busy"});
            // R5: triggers inside the window must change nothing
            if (c == j + 20 || c == j + 7 * TD) begin
                ocp_hw = 1'b1; sw_off = 1'b1;
            end
            @(negedge clk);
            ocp_hw = 0; sw_off = 0;
        end
        // restore levels; the reverse edges must not trigger (R8, R9)
        card_present = 1'b1; detect_en = 1'b0;
        host_cmd = 1'b0; supply_fail = 1'b0; supply_mon_en = 1'b0;
        chip_rstn = 1'b1;
        check_idle(12, "R5 R8 R9 reverse edge");
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(outs(), 6'b0, "R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        check(outs(), 6'b0, "R1 after reset");
        check_idle(10, "R1 idle");

        // R6: software-written overcurrent flag is ignored
        ocp_sw = 1'b1;
        @(negedge clk);
        ocp_sw = 1'b0;
        check_idle(12, "R6 ocp_sw");

        // R7: qualifiers disabled
        detect_en = 1'b0; card_present = 1'b0;
        @(negedge clk);
        check_idle(12, "R7 removal no detect");
        card_present = 1'b1;
        supply_mon_en = 1'b0; supply_fail = 1'b1;
        @(negedge clk);
        check_idle(12, "R7 fail no monitor");
        supply_fail = 1'b0;
        @(negedge clk);

        for (int kind = 0; kind < 8; kind++)
            for (int ph = 0; ph < TD; ph++)
                run_seq(kind, ph);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule